// File: doc/BRIEF.md
# FM Read Clock/Data Separator

This block takes the composite pulse stream recovered from an FM-encoded floppy track and splits it into two streams: a separated clock and a separated data stream. In FM coding every bit cell starts with a clock pulse. A "one" also has a data pulse near the middle of the cell. The separator treats a pulse that arrives while no window is open as a clock pulse. That pulse starts a fixed one-shot window of about three quarters of a bit cell. A pulse whose leading edge falls inside the window is a "one" bit, and it is reported when its trailing edge arrives. A window with no such pulse leaves the data output quiet for that cell.

The window is a count of system clock cycles, set by a parameter. The nominal cell is 4 µs at 250 kbit/s, so the window is about 2.9 µs. Once a data pulse has been captured, any further pulse in the same window is ignored, so it cannot be taken for a clock. The block works only while reading, which means the head is loaded and write enable is low. A sync flag tells the consumer when enough clock-only cells have been seen for the alignment to be trusted. The input pulse is sampled by one register and then edge-detected. All outputs are registered.

Top module: `fm_read_separator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sep_clk`, `sep_data` and `synced` are all 0.
- R2: A pulse whose leading edge arrives while no window is open produces a `sep_clk` pulse that is exactly one cycle wide. That pulse is high in the second cycle after the first clock edge that samples `pulse_in` high. The same pulse opens a window of WIN_CYCLES cycles.
- R3: A pulse whose first sampled-high edge is 1 to WIN_CYCLES-1 cycles after the clock pulse's first sampled-high edge is a data bit. It produces no `sep_clk`. It produces a one-cycle `sep_data` pulse that is high in the second cycle after the first edge that samples `pulse_in` low again.
- R4: A cell that holds only a clock pulse produces no `sep_data` pulse.
- R5: After a data pulse has been captured, any further pulse in the same window produces neither `sep_clk` nor `sep_data`.
- R6: A pulse whose first sampled-high edge is WIN_CYCLES+1 cycles after the clock pulse's first sampled-high edge falls outside the window. It is taken as a new clock pulse and gives `sep_clk` with no `sep_data`.
- R7: `synced` rises after SYNC_CELLS consecutive clock-only windows have closed. A data window that closes before sync is reached restarts the count. Once set, `synced` stays high while reading stays enabled.
- R8: While `head_loaded` is low or `write_en` is high, every state is cleared at each clock edge. From the next cycle on, `sep_clk`, `sep_data` and `synced` are 0.
- R9: `sep_clk` and `sep_data` are never high in the same cycle, and each pulse is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| head_loaded | input | 1 | Head is loaded on the media |
| write_en | input | 1 | Write enable; high blocks reading |
| pulse_in | input | 1 | Composite clock-and-data read pulse |
| sep_clk | output | 1 | One-cycle separated clock pulse |
| sep_data | output | 1 | One-cycle separated "one" data pulse |
| synced | output | 1 | Preamble of clock-only cells seen |

## Verification
Bytes are sent as full FM cells behind a two-cell zero preamble. The patterns are all zeros, all ones, alternating bits and mixed bits. The bench rebuilds each byte from the output pulses, so a lost bit, a clock taken as data, or data taken as a clock each shows up as a wrong byte or a wrong pulse count. Directed tests pin down the exact latency of the clock and data pulses. They place a pulse just inside the window and just past it to show where the window ends. They also place a stray pulse after a captured data bit. A further test interrupts the preamble with a data cell to show that the sync count restarts. The last tests toggle the head-loaded and write-enable inputs to show that they clear the outputs and the sync flag.

// File: rtl/fmsep_pkg.sv
package fmsep_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } pulse_edge_t;
endpackage

// File: rtl/fmsep_edge.sv
module fmsep_edge
  import fmsep_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        pulse_in,
  output pulse_edge_t ev
);
  logic smp_q, smp_prev_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      smp_q      <= 1'b0;
      smp_prev_q <= 1'b0;
    end else begin
      smp_q      <= pulse_in;
      smp_prev_q <= smp_q;
    end
  end

  assign ev.rise = smp_q & ~smp_prev_q;
  assign ev.fall = ~smp_q & smp_prev_q;
endmodule

// File: rtl/fmsep_window.sv
module fmsep_window
  import fmsep_pkg::*;
#(
  parameter int WIN_CYCLES = 29
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  pulse_edge_t ev,
  output logic        sep_clk,
  output logic        sep_data,
  output logic        cell_done,
  output logic        cell_data
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN_CYCLES - 1);

  logic          open_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q;   // data leading edge captured this window
  logic          taken_q;  // data trailing edge already reported
  logic          pending;

  assign pending = seen_q & ~taken_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      open_q    <= 1'b0;
      cnt_q     <= '0;
      seen_q    <= 1'b0;
      taken_q   <= 1'b0;
      sep_clk   <= 1'b0;
      sep_data  <= 1'b0;
      cell_done <= 1'b0;
      cell_data <= 1'b0;
    end else begin
      sep_clk   <= 1'b0;
      sep_data  <= 1'b0;
      cell_done <= 1'b0;
      if (open_q) begin
        if (cnt_q == '0) begin
          open_q    <= 1'b0;
          cell_done <= 1'b1;
          cell_data <= seen_q;
          if (!pending) begin
            seen_q  <= 1'b0;
            taken_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (ev.rise && !seen_q) seen_q <= 1'b1;
        end
      end else if (ev.rise && !pending) begin
        open_q  <= 1'b1;
        cnt_q   <= LOAD;
        sep_clk <= 1'b1;
      end
      if (ev.fall && pending) begin
        sep_data <= 1'b1;
        if (open_q && cnt_q != '0) begin
          taken_q <= 1'b1;
        end else begin
          seen_q  <= 1'b0;
          taken_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fmsep_sync.sv
module fmsep_sync #(
  parameter int SYNC_CELLS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cell_done,
  input  logic cell_data,
  output logic synced
);
  localparam int SW = $clog2(SYNC_CELLS + 1);
  localparam logic [SW-1:0] LAST = SW'(SYNC_CELLS - 1);

  logic [SW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q  <= '0;
      synced <= 1'b0;
    end else if (cell_done && !synced) begin
      if (cell_data) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        synced <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fm_read_separator.sv
module fm_read_separator
  import fmsep_pkg::*;
#(
  parameter int WIN_CYCLES = 29,
  parameter int SYNC_CELLS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic head_loaded,
  input  logic write_en,
  input  logic pulse_in,
  output logic sep_clk,
  output logic sep_data,
  output logic synced
);
  logic        rd_clr;
  pulse_edge_t ev;
  logic        cell_done, cell_data;

  assign rd_clr = ~(head_loaded & ~write_en);

  fmsep_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .clr      (rd_clr),
    .pulse_in (pulse_in),
    .ev       (ev)
  );

  fmsep_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk       (clk),
    .rst       (rst),
    .clr       (rd_clr),
    .ev        (ev),
    .sep_clk   (sep_clk),
    .sep_data  (sep_data),
    .cell_done (cell_done),
    .cell_data (cell_data)
  );

  fmsep_sync #(.SYNC_CELLS(SYNC_CELLS)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .clr       (rd_clr),
    .cell_done (cell_done),
    .cell_data (cell_data),
    .synced    (synced)
  );
endmodule

// File: rtl/fm_read_separator_chk.sv
module fm_read_separator_chk (
  input logic clk,
  input logic rst,
  input logic head_loaded,
  input logic write_en,
  input logic sep_clk,
  input logic sep_data,
  input logic synced
);
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(sep_clk && sep_data));

  p_clk_width_r9: assert property (@(posedge clk) disable iff (rst)
    sep_clk |=> !sep_clk);

  p_data_width_r9: assert property (@(posedge clk) disable iff (rst)
    sep_data |=> !sep_data);

  p_disable_r8: assert property (@(posedge clk) disable iff (rst)
    !(head_loaded && !write_en) |=> (!sep_clk && !sep_data && !synced));

  p_sync_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (synced && head_loaded && !write_en) |=> synced);
endmodule

bind fm_read_separator fm_read_separator_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .head_loaded (head_loaded),
  .write_en    (write_en),
  .sep_clk     (sep_clk),
  .sep_data    (sep_data),
  .synced      (synced)
);

// File: tb/fm_read_separator_bench.sv
`timescale 1ns/1ps
module fm_read_separator_bench;
  localparam int CLK_PERIOD = 100;
  localparam int WIN  = 29;
  localparam int CELL = 40;
  localparam int HALF = 20;
  localparam int PW   = 3;
  localparam int MAX_CYCLES = 150000;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};

  logic clk = 1'b0;
  logic rst, head_loaded, write_en, pulse_in;
  logic sep_clk, sep_data, synced;

  int tests = 0;
  int fails = 0;
  int nclk = 0;
  int ndata = 0;
  logic [15:0] shreg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_read_separator #(.WIN_CYCLES(WIN), .SYNC_CELLS(2)) u_fm_read_separator (
    .clk(clk), .rst(rst), .head_loaded(head_loaded), .write_en(write_en),
    .pulse_in(pulse_in), .sep_clk(sep_clk), .sep_data(sep_data), .synced(synced)
  );

  // Rebuild the bit stream from the output pulses.
  always @(negedge clk) begin
    if (sep_clk) begin
      shreg = {shreg[14:0], 1'b0};
      nclk  = nclk + 1;
    end
    if (sep_data) begin
      shreg[0] = 1'b1;
      ndata = ndata + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    nclk = 0; ndata = 0; shreg = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    pulse_in = 1'b1;
    idle(PW);
    pulse_in = 1'b0;
  endtask

  task automatic send_cell(input bit one);
    pulse();
    idle(HALF - PW);
    if (one) begin
      pulse();
      idle(CELL - HALF - PW);
    end else begin
      idle(CELL - HALF);
    end
  endtask

  // clock pulse, then a second pulse whose leading edge is gap cycles later
  task automatic send_pair(input int gap);
    pulse();
    idle(gap - PW);
    pulse();
    idle(CELL + 20);
  endtask

  task automatic restart();
    head_loaded = 1'b0;
    idle(2);
    head_loaded = 1'b1;
    idle(2);
    clear_counts();
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", MAX_CYCLES, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; head_loaded = 1'b1; write_en = 1'b0; pulse_in = 1'b0;
    idle(4);
    check("R1 sep_clk in reset", int'(sep_clk), 0);
    check("R1 sep_data in reset", int'(sep_data), 0);
    check("R1 synced in reset", int'(synced), 0);
    rst = 1'b0;
    idle(1);
    check("R1 outputs after reset", int'({sep_clk, sep_data, synced}), 0);
    clear_counts();

    // Table walk: preamble plus one byte, MSB first (R2 R3 R4 R7 R9)
    for (int i = 0; i < NVEC; i++) begin
      restart();
      send_cell(1'b0);
      send_cell(1'b0);
      for (int b = 7; b >= 0; b--) send_cell(VEC[i][b]);
      idle(CELL);
      check("R3 R4 decoded byte", int'(shreg[7:0]), int'(VEC[i]));
      check("R2 clock count", nclk, 10);
      check("R3 data count", ndata, $countones(VEC[i]));
      check("R7 synced after preamble", int'(synced), 1);
    end

    // R2 exact clock latency
    restart();
    pulse_in = 1'b1;
    idle(1);
    check("R2 sep_clk not yet", int'(sep_clk), 0);
    idle(1);
    check("R2 sep_clk latency", int'(sep_clk), 1);
    idle(1);
    check("R9 sep_clk one cycle", int'(sep_clk), 0);
    pulse_in = 1'b0;
    idle(HALF - PW);
    // R3 exact data latency: data pulse high 3 cycles, then low
    pulse();
    idle(1);
    check("R3 sep_data not yet", int'(sep_data), 0);
    idle(1);
    check("R3 sep_data latency", int'(sep_data), 1);
    idle(1);
    check("R9 sep_data one cycle", int'(sep_data), 0);
    idle(CELL + 20);
    check("R3 no clock from data pulse", nclk, 1);

    // R3 boundary: last cycle inside window
    restart();
    send_pair(WIN - 1);
    check("R3 late-in-window is data", ndata, 1);
    check("R3 late-in-window no clock", nclk, 1);

    // R6 boundary: just past window
    restart();
    send_pair(WIN + 1);
    check("R6 past window is clock", nclk, 2);
    check("R6 past window no data", ndata, 0);

    // R5: stray pulse after captured data
    restart();
    pulse();
    idle(10 - PW);
    pulse();
    idle(10 - PW);
    pulse();
    idle(CELL + 20);
    check("R5 stray clock count", nclk, 1);
    check("R5 stray data count", ndata, 1);

    // R7: data cell restarts preamble count
    restart();
    send_cell(1'b0);
    check("R7 one clean cell", int'(synced), 0);
    send_cell(1'b1);
    check("R7 data cell restarts", int'(synced), 0);
    send_cell(1'b0);
    check("R7 one clean after restart", int'(synced), 0);
    send_cell(1'b0);
    check("R7 two clean cells", int'(synced), 1);

    // R8: write enable blocks reading and clears sync
    write_en = 1'b1;
    idle(2);
    check("R8 synced cleared by write_en", int'(synced), 0);
    clear_counts();
    send_cell(1'b1);
    check("R8 write_en no clock", nclk, 0);
    check("R8 write_en no data", ndata, 0);
    write_en = 1'b0;
    send_cell(1'b0);
    send_cell(1'b0);
    check("R8 synced again after enable", int'(synced), 1);
    head_loaded = 1'b0;
    idle(2);
    check("R8 synced cleared by unload", int'(synced), 0);
    clear_counts();
    send_cell(1'b1);
    check("R8 unloaded no pulses", nclk + ndata, 0);
    head_loaded = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule